// File: doc/BRIEF.md
# Exception Entry Dispatch

This block makes the exception-entry decision for a small 32-bit core. Two kinds of event reach it. A general exception arrives with a trigger, a cause code, the faulting PC and an address that may or may not be valid. A debug exception arrives with a trigger, a debug cause and a PC. On the clock edge after a trigger, the block updates the core's exception state registers. It also emits a one-cycle, one-hot pulse that names the vector the core must fetch from next.

The block holds the following state:
- A processor status word with a user-mode bit, an exception-mode bit and an interrupt level.
- A primary saved PC.
- An optional separate saved PC for double exceptions.
- The general cause and the faulting address.
- The debug cause.
- One saved PC and one saved status word for each interrupt level from 2 up to the configured debug level.

Whenever no exception is taken in a cycle, the core may overwrite the status word through a write port.

Top module: `exc_dispatch`

## Requirements
- R1: After reset, every stored register, the status word and the vector output are all zero.
- R2: A general exception taken while the exception-mode bit is clear saves its PC to the primary saved PC. With the user-mode bit also clear, it selects the kernel vector (`vec_o` = 4'b0001).
- R3: A general exception taken with the exception-mode bit clear and the user-mode bit set selects the user vector (`vec_o` = 4'b0010).
- R4: A general exception taken with the exception-mode bit already set selects the double vector (`vec_o` = 4'b0100).
  - When `HAS_DBL_PC` is 1, the PC goes to the double-exception saved PC and the primary saved PC keeps its value.
  - When `HAS_DBL_PC` is 0, the PC goes to the primary saved PC.
- R5: Every general exception taken writes its cause to `exc_cause_o` and sets the exception-mode bit. The other status fields keep their values.
- R6: The faulting address register loads `gen_addr_i` only on a general exception taken with `gen_addr_vld_i` high. Otherwise it keeps its value.
- R7: A debug request is taken only when the current interrupt level is strictly below `DBG_LVL`. Otherwise it changes no register and produces no vector pulse.
- R8: A debug exception that is taken performs all of the following updates:
  - It writes the debug cause.
  - It writes the PC into the level slot for `DBG_LVL`, which is slot `DBG_LVL-2` of `lvl_pc_o`, with each slot `XLEN` bits wide.
  - It writes the old status word into the same slot of `lvl_stat_o`.
  - It sets the interrupt level to `DBG_LVL` and sets the exception-mode bit.
  - It selects the debug vector (`vec_o` = 4'b1000).
- R9: When a general and a debug request arrive in the same cycle, the debug exception is taken if R7 allows it. The general exception is then dropped, and its cause and PC are not stored. Otherwise the general exception is taken.
- R10: `vec_o` is a registered pulse. It is one-hot for exactly the cycle after each taken exception and zero in every other cycle.
- R11: `stat_wr_i` loads `stat_wdata_i` into the status word when no exception is taken that cycle. A taken exception overrides the write.
  - Status bit layout: [5] user mode, [4] exception mode, [3:0] interrupt level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gen_req_i | input | 1 | General exception trigger |
| gen_cause_i | input | CAUSE_W | General exception cause code |
| gen_pc_i | input | XLEN | PC of the faulting instruction |
| gen_addr_vld_i | input | 1 | Faulting address is valid |
| gen_addr_i | input | XLEN | Faulting virtual address |
| dbg_req_i | input | 1 | Debug exception trigger |
| dbg_cause_i | input | DCAUSE_W | Debug cause |
| dbg_pc_i | input | XLEN | PC at the debug event |
| stat_wr_i | input | 1 | Status word write strobe |
| stat_wdata_i | input | 6 | Status word write data |
| vec_o | output | 4 | One-hot vector select pulse |
| stat_o | output | 6 | Current status word |
| epc_o | output | XLEN | Primary saved PC |
| dbl_pc_o | output | XLEN | Double-exception saved PC (zero when not configured) |
| exc_cause_o | output | CAUSE_W | Last general cause |
| fault_addr_o | output | XLEN | Last faulting address |
| dbg_cause_o | output | DCAUSE_W | Last debug cause |
| lvl_pc_o | output | (DBG_LVL-1)*XLEN | Per-level saved PCs, levels 2 up to DBG_LVL |
| lvl_stat_o | output | (DBG_LVL-1)*6 | Per-level saved status words |

## Verification
The assertions check the following on every cycle:
- the vector output is one-hot or zero;
- an idle cycle is followed by no pulse, and a general request is always followed by a pulse;
- every general request sets the exception-mode bit and stores its cause;
- a blocked debug request leaves the status untouched;
- a debug pulse coincides with the interrupt level equal to the debug level;
- a double pulse only follows a set exception-mode bit;
- the faulting address stays put without a general request.

The following are shown only by the bench's scenarios, run against a behavioural model on two instances (with and without the double-exception PC):
- where the PC lands;
- the contents of the per-level slots;
- the choice between user and kernel vectors;
- arbitration of simultaneous triggers;
- a status write losing to an exception.

// File: rtl/exc_disp_pkg.sv
package exc_disp_pkg;
  localparam int ILVL_W = 4;
  localparam int STAT_W = ILVL_W + 2;
  localparam int EXCM_BIT = ILVL_W;
  localparam int UM_BIT = ILVL_W + 1;

  typedef struct packed {
    logic              um;
    logic              excm;
    logic [ILVL_W-1:0] ilvl;
  } status_t;

  typedef enum logic [3:0] {
    VEC_NONE   = 4'b0000,
    VEC_KERNEL = 4'b0001,
    VEC_USER   = 4'b0010,
    VEC_DOUBLE = 4'b0100,
    VEC_DEBUG  = 4'b1000
  } vec_e;
endpackage

// File: rtl/exc_disp_decide.sv
module exc_disp_decide
  import exc_disp_pkg::*;
#(
  parameter int DBG_LVL    = 6,
  parameter bit HAS_DBL_PC = 1'b1
) (
  input  status_t cur_stat_i,
  input  logic    gen_req_i,
  input  logic    dbg_req_i,
  input  logic    stat_wr_i,
  input  status_t stat_wdata_i,
  output logic    take_gen_o,
  output logic    take_dbg_o,
  output logic    save_dbl_o,
  output status_t nxt_stat_o,
  output vec_e    nxt_vec_o
);
  localparam logic [ILVL_W-1:0] DBG_ILVL = ILVL_W'(DBG_LVL);

  logic dbg_ok;
  assign dbg_ok     = dbg_req_i && (cur_stat_i.ilvl < DBG_ILVL);
  assign take_dbg_o = dbg_ok;
  assign take_gen_o = gen_req_i && !dbg_ok;
  assign save_dbl_o = take_gen_o && cur_stat_i.excm && HAS_DBL_PC;

  always_comb begin
    nxt_stat_o = cur_stat_i;
    nxt_vec_o  = VEC_NONE;
    if (take_dbg_o) begin
      nxt_stat_o.ilvl = DBG_ILVL;
      nxt_stat_o.excm = 1'b1;
      nxt_vec_o       = VEC_DEBUG;
    end else if (take_gen_o) begin
      nxt_stat_o.excm = 1'b1;
      if (cur_stat_i.excm)    nxt_vec_o = VEC_DOUBLE;
      else if (cur_stat_i.um) nxt_vec_o = VEC_USER;
      else                    nxt_vec_o = VEC_KERNEL;
    end else if (stat_wr_i) begin
      nxt_stat_o = stat_wdata_i;
    end
  end
endmodule

// File: rtl/exc_disp_regs.sv
module exc_disp_regs
  import exc_disp_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 6,
  parameter int DCAUSE_W   = 6,
  parameter int DBG_LVL    = 6,
  parameter bit HAS_DBL_PC = 1'b1,
  localparam int NSLOT     = DBG_LVL - 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    take_gen_i,
  input  logic                    take_dbg_i,
  input  logic                    save_dbl_i,
  input  logic [XLEN-1:0]         gen_pc_i,
  input  logic [CAUSE_W-1:0]      gen_cause_i,
  input  logic                    gen_addr_vld_i,
  input  logic [XLEN-1:0]         gen_addr_i,
  input  logic [XLEN-1:0]         dbg_pc_i,
  input  logic [DCAUSE_W-1:0]     dbg_cause_i,
  input  status_t                 old_stat_i,
  output logic [XLEN-1:0]         epc_o,
  output logic [XLEN-1:0]         dbl_pc_o,
  output logic [CAUSE_W-1:0]      cause_o,
  output logic [XLEN-1:0]         addr_o,
  output logic [DCAUSE_W-1:0]     dcause_o,
  output logic [NSLOT*XLEN-1:0]   lvl_pc_o,
  output logic [NSLOT*STAT_W-1:0] lvl_stat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_o    <= '0;
      cause_o  <= '0;
      addr_o   <= '0;
      dcause_o <= '0;
    end else begin
      if (take_gen_i) cause_o <= gen_cause_i;
      if (take_gen_i && !save_dbl_i) epc_o <= gen_pc_i;
      if (take_gen_i && gen_addr_vld_i) addr_o <= gen_addr_i;
      if (take_dbg_i) dcause_o <= dbg_cause_i;
    end
  end

  if (HAS_DBL_PC) begin : g_dbl
    logic [XLEN-1:0] dbl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dbl_q <= '0;
      else if (save_dbl_i) dbl_q <= gen_pc_i;
    end
    assign dbl_pc_o = dbl_q;
  end else begin : g_no_dbl
    assign dbl_pc_o = '0;
  end

  // slot g holds level g+2; only the debug level slot is written here
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam bit IS_DBG = (g + 2 == DBG_LVL);
    logic [XLEN-1:0]   pc_q;
    logic [STAT_W-1:0] st_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pc_q <= '0;
        st_q <= '0;
      end else if (take_dbg_i && IS_DBG) begin
        pc_q <= dbg_pc_i;
        st_q <= old_stat_i;
      end
    end
    assign lvl_pc_o[g*XLEN +: XLEN]       = pc_q;
    assign lvl_stat_o[g*STAT_W +: STAT_W] = st_q;
  end
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
  import exc_disp_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 6,
  parameter int DCAUSE_W   = 6,
  parameter int DBG_LVL    = 6,
  parameter bit HAS_DBL_PC = 1'b1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           gen_req_i,
  input  logic [CAUSE_W-1:0]             gen_cause_i,
  input  logic [XLEN-1:0]                gen_pc_i,
  input  logic                           gen_addr_vld_i,
  input  logic [XLEN-1:0]                gen_addr_i,
  input  logic                           dbg_req_i,
  input  logic [DCAUSE_W-1:0]            dbg_cause_i,
  input  logic [XLEN-1:0]                dbg_pc_i,
  input  logic                           stat_wr_i,
  input  logic [STAT_W-1:0]              stat_wdata_i,
  output logic [3:0]                     vec_o,
  output logic [STAT_W-1:0]              stat_o,
  output logic [XLEN-1:0]                epc_o,
  output logic [XLEN-1:0]                dbl_pc_o,
  output logic [CAUSE_W-1:0]             exc_cause_o,
  output logic [XLEN-1:0]                fault_addr_o,
  output logic [DCAUSE_W-1:0]            dbg_cause_o,
  output logic [(DBG_LVL-1)*XLEN-1:0]    lvl_pc_o,
  output logic [(DBG_LVL-1)*STAT_W-1:0]  lvl_stat_o
);
  status_t stat_q, nxt_stat;
  vec_e    vec_q, nxt_vec;
  logic    take_gen, take_dbg, save_dbl;

  exc_disp_decide #(
    .DBG_LVL   (DBG_LVL),
    .HAS_DBL_PC(HAS_DBL_PC)
  ) decide_i (
    .cur_stat_i  (stat_q),
    .gen_req_i   (gen_req_i),
    .dbg_req_i   (dbg_req_i),
    .stat_wr_i   (stat_wr_i),
    .stat_wdata_i(status_t'(stat_wdata_i)),
    .take_gen_o  (take_gen),
    .take_dbg_o  (take_dbg),
    .save_dbl_o  (save_dbl),
    .nxt_stat_o  (nxt_stat),
    .nxt_vec_o   (nxt_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      vec_q  <= VEC_NONE;
    end else begin
      stat_q <= nxt_stat;
      vec_q  <= nxt_vec;
    end
  end

  exc_disp_regs #(
    .XLEN      (XLEN),
    .CAUSE_W   (CAUSE_W),
    .DCAUSE_W  (DCAUSE_W),
    .DBG_LVL   (DBG_LVL),
    .HAS_DBL_PC(HAS_DBL_PC)
  ) regs_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .take_gen_i    (take_gen),
    .take_dbg_i    (take_dbg),
    .save_dbl_i    (save_dbl),
    .gen_pc_i      (gen_pc_i),
    .gen_cause_i   (gen_cause_i),
    .gen_addr_vld_i(gen_addr_vld_i),
    .gen_addr_i    (gen_addr_i),
    .dbg_pc_i      (dbg_pc_i),
    .dbg_cause_i   (dbg_cause_i),
    .old_stat_i    (stat_q),
    .epc_o         (epc_o),
    .dbl_pc_o      (dbl_pc_o),
    .cause_o       (exc_cause_o),
    .addr_o        (fault_addr_o),
    .dcause_o      (dbg_cause_o),
    .lvl_pc_o      (lvl_pc_o),
    .lvl_stat_o    (lvl_stat_o)
  );

  assign stat_o = stat_q;
  assign vec_o  = vec_q;
endmodule

// File: rtl/exc_dispatch_chk.sv
module exc_dispatch_chk
  import exc_disp_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int CAUSE_W  = 6,
  parameter int DBG_LVL  = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               gen_req_i,
  input logic [CAUSE_W-1:0] gen_cause_i,
  input logic               dbg_req_i,
  input logic               stat_wr_i,
  input logic [3:0]         vec_o,
  input logic [STAT_W-1:0]  stat_o,
  input logic [CAUSE_W-1:0] exc_cause_o,
  input logic [XLEN-1:0]    fault_addr_o
);
  localparam logic [ILVL_W-1:0] DL = ILVL_W'(DBG_LVL);
  logic dbg_allowed;
  assign dbg_allowed = dbg_req_i && (stat_o[ILVL_W-1:0] < DL);

  AST_VEC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(vec_o)); // R10
  AST_IDLE_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gen_req_i && !dbg_req_i) |=> (vec_o == 4'b0000)); // R10
  AST_GEN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_req_i |=> (vec_o != 4'b0000)); // R10
  AST_GEN_EXCM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_req_i |=> stat_o[EXCM_BIT]); // R5
  AST_GEN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_req_i && !dbg_allowed) |=> (exc_cause_o == $past(gen_cause_i))); // R5
  AST_DBG_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_req_i && !gen_req_i && !stat_wr_i && !dbg_allowed)
      |=> ($stable(stat_o) && vec_o == 4'b0000)); // R7
  AST_DBG_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_o == VEC_DEBUG) |-> (stat_o[ILVL_W-1:0] == DL && stat_o[EXCM_BIT])); // R8
  AST_DBL_NEEDS_EXCM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_req_i && !dbg_allowed && !stat_o[EXCM_BIT]) |=> (vec_o != VEC_DOUBLE)); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_req_i |=> $stable(fault_addr_o)); // R6
endmodule

bind exc_dispatch exc_dispatch_chk #(
  .XLEN   (XLEN),
  .CAUSE_W(CAUSE_W),
  .DBG_LVL(DBG_LVL)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gen_req_i   (gen_req_i),
  .gen_cause_i (gen_cause_i),
  .dbg_req_i   (dbg_req_i),
  .stat_wr_i   (stat_wr_i),
  .vec_o       (vec_o),
  .stat_o      (stat_o),
  .exc_cause_o (exc_cause_o),
  .fault_addr_o(fault_addr_o)
);

// File: tb/exc_dispatch_tb_top.sv
`timescale 1ns/1ps
module exc_dispatch_tb_top;
  localparam int XLEN = 32, CW = 6, DW = 6, DL = 6, NS = DL - 1, SW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic gen_req = 0, addr_vld = 0, dbg_req = 0, stat_wr = 0;
  logic [CW-1:0] gen_cause = '0;
  logic [DW-1:0] dbg_cause = '0;
  logic [XLEN-1:0] gen_pc = '0, gen_addr = '0, dbg_pc = '0;
  logic [SW-1:0] stat_wd = '0;

  logic [3:0]         vec_w[2];
  logic [SW-1:0]      stat_w[2];
  logic [XLEN-1:0]    epc_w[2], dbl_w[2], addr_w[2];
  logic [CW-1:0]      cause_w[2];
  logic [DW-1:0]      dc_w[2];
  logic [NS*XLEN-1:0] lpc_w[2];
  logic [NS*SW-1:0]   lst_w[2];

  exc_dispatch #(.XLEN(XLEN), .CAUSE_W(CW), .DCAUSE_W(DW), .DBG_LVL(DL), .HAS_DBL_PC(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .gen_req_i(gen_req), .gen_cause_i(gen_cause), .gen_pc_i(gen_pc),
    .gen_addr_vld_i(addr_vld), .gen_addr_i(gen_addr), .dbg_req_i(dbg_req), .dbg_cause_i(dbg_cause),
    .dbg_pc_i(dbg_pc), .stat_wr_i(stat_wr), .stat_wdata_i(stat_wd), .vec_o(vec_w[0]), .stat_o(stat_w[0]),
    .epc_o(epc_w[0]), .dbl_pc_o(dbl_w[0]), .exc_cause_o(cause_w[0]), .fault_addr_o(addr_w[0]),
    .dbg_cause_o(dc_w[0]), .lvl_pc_o(lpc_w[0]), .lvl_stat_o(lst_w[0]));

  exc_dispatch #(.XLEN(XLEN), .CAUSE_W(CW), .DCAUSE_W(DW), .DBG_LVL(DL), .HAS_DBL_PC(1'b0)) dut_nd_i (
    .clk_i(clk), .rst_ni(rst_n), .gen_req_i(gen_req), .gen_cause_i(gen_cause), .gen_pc_i(gen_pc),
    .gen_addr_vld_i(addr_vld), .gen_addr_i(gen_addr), .dbg_req_i(dbg_req), .dbg_cause_i(dbg_cause),
    .dbg_pc_i(dbg_pc), .stat_wr_i(stat_wr), .stat_wdata_i(stat_wd), .vec_o(vec_w[1]), .stat_o(stat_w[1]),
    .epc_o(epc_w[1]), .dbl_pc_o(dbl_w[1]), .exc_cause_o(cause_w[1]), .fault_addr_o(addr_w[1]),
    .dbg_cause_o(dc_w[1]), .lvl_pc_o(lpc_w[1]), .lvl_stat_o(lst_w[1]));

  // behavioural reference model, index 0 with double PC, index 1 without
  int unsigned m_vec[2], m_stat[2], m_epc[2], m_dbl[2], m_cause[2], m_addr[2], m_dc[2];
  int unsigned m_lpc[2][NS], m_lst[2][NS];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_vec[k] = 0; m_stat[k] = 0; m_epc[k] = 0; m_dbl[k] = 0;
        m_cause[k] = 0; m_addr[k] = 0; m_dc[k] = 0;
        for (int s = 0; s < NS; s++) begin m_lpc[k][s] = 0; m_lst[k][s] = 0; end
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        int unsigned il, excm, um;
        il = m_stat[k] % 16; excm = (m_stat[k] / 16) % 2; um = m_stat[k] / 32;
        if (dbg_req && il < DL) begin
          m_dc[k] = dbg_cause;
          m_lpc[k][DL-2] = dbg_pc;
          m_lst[k][DL-2] = m_stat[k];
          m_stat[k] = um * 32 + 16 + DL;
          m_vec[k] = 8;
        end else if (gen_req) begin
          m_cause[k] = gen_cause;
          if (addr_vld) m_addr[k] = gen_addr;
          if (excm == 1) begin
            m_vec[k] = 4;
            if (k == 0) m_dbl[k] = gen_pc; else m_epc[k] = gen_pc;
          end else begin
            m_vec[k] = (um == 1) ? 2 : 1;
            m_epc[k] = gen_pc;
          end
          m_stat[k] = um * 32 + 16 + il;
        end else begin
          m_vec[k] = 0;
          if (stat_wr) m_stat[k] = stat_wd;
        end
      end
    end
  end

  int checks = 0, errors = 0;
  task automatic chk(input string req, input string what, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  logic run_cmp = 0;
  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      for (int k = 0; k < 2; k++) begin
        chk("R10", "vec", XLEN'(vec_w[k]), m_vec[k]);
        chk("R11", "stat", XLEN'(stat_w[k]), m_stat[k]);
        chk("R2", "epc", epc_w[k], m_epc[k]);
        chk("R4", "dbl_pc", dbl_w[k], m_dbl[k]);
        chk("R5", "cause", XLEN'(cause_w[k]), m_cause[k]);
        chk("R6", "addr", addr_w[k], m_addr[k]);
        chk("R8", "dbg_cause", XLEN'(dc_w[k]), m_dc[k]);
        for (int s = 0; s < NS; s++) begin
          chk("R8", "lvl_pc", lpc_w[k][s*XLEN +: XLEN], m_lpc[k][s]);
          chk("R8", "lvl_stat", XLEN'(lst_w[k][s*SW +: SW]), m_lst[k][s]);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    gen_req = 0; dbg_req = 0; stat_wr = 0; addr_vld = 0;
  endtask

  task automatic wstat(input logic [SW-1:0] v);
    stat_wr = 1; stat_wd = v; tick();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "vec in reset", XLEN'(vec_w[0]), 0);
    rst_n = 1;
    run_cmp = 1;
    tick();
    chk("R1", "stat after reset", XLEN'(stat_w[0]), 0);
    chk("R1", "epc after reset", epc_w[0], 0);
    chk("R1", "lvl_pc after reset", lpc_w[0][(DL-2)*XLEN +: XLEN], 0);

    gen_req = 1; gen_cause = 6'h05; gen_pc = 32'h100; addr_vld = 1; gen_addr = 32'hdead_beef; tick();
    chk("R2", "kernel vec", XLEN'(vec_w[0]), 1);
    chk("R2", "epc", epc_w[0], 32'h100);
    chk("R6", "addr loaded", addr_w[0], 32'hdead_beef);
    chk("R5", "excm set", XLEN'(stat_w[0]), 32'h10);

    wstat(6'h20);
    chk("R11", "stat write", XLEN'(stat_w[0]), 32'h20);

    gen_req = 1; gen_cause = 6'h07; gen_pc = 32'h200; addr_vld = 0; gen_addr = 32'h1234; tick();
    chk("R3", "user vec", XLEN'(vec_w[0]), 2);
    chk("R6", "addr kept", addr_w[0], 32'hdead_beef);
    chk("R5", "cause", XLEN'(cause_w[0]), 32'h07);

    gen_req = 1; gen_cause = 6'h09; gen_pc = 32'h300; tick();
    chk("R4", "double vec", XLEN'(vec_w[0]), 4);
    chk("R4", "dbl_pc", dbl_w[0], 32'h300);
    chk("R4", "epc kept", epc_w[0], 32'h200);
    chk("R4", "no-dbl epc", epc_w[1], 32'h300);

    wstat(6'h06);
    dbg_req = 1; dbg_cause = 6'h03; dbg_pc = 32'h400; tick();
    chk("R7", "blocked vec", XLEN'(vec_w[0]), 0);
    chk("R7", "blocked stat", XLEN'(stat_w[0]), 32'h06);
    chk("R7", "blocked dcause", XLEN'(dc_w[0]), 0);

    wstat(6'h03);
    dbg_req = 1; dbg_cause = 6'h11; dbg_pc = 32'h500; tick();
    chk("R8", "debug vec", XLEN'(vec_w[0]), 8);
    chk("R8", "debug stat", XLEN'(stat_w[0]), 32'h16);
    chk("R8", "debug slot pc", lpc_w[0][(DL-2)*XLEN +: XLEN], 32'h500);
    chk("R8", "debug slot stat", XLEN'(lst_w[0][(DL-2)*SW +: SW]), 32'h03);

    wstat(6'h02);
    gen_req = 1; gen_cause = 6'h21; gen_pc = 32'h600;
    dbg_req = 1; dbg_cause = 6'h05; dbg_pc = 32'h610; tick();
    chk("R9", "debug wins", XLEN'(vec_w[0]), 8);
    chk("R9", "gen cause dropped", XLEN'(cause_w[0]), 32'h09);

    wstat(6'h06);
    gen_req = 1; gen_cause = 6'h22; gen_pc = 32'h700;
    dbg_req = 1; dbg_pc = 32'h710; tick();
    chk("R9", "gen wins when blocked", XLEN'(vec_w[0]), 1);
    chk("R9", "gen epc", epc_w[0], 32'h700);

    stat_wr = 1; stat_wd = 6'h00; gen_req = 1; gen_cause = 6'h01; gen_pc = 32'h800; tick();
    chk("R11", "exception overrides write", XLEN'(stat_w[0]), 32'h16);
    chk("R10", "pulse", XLEN'(vec_w[0]), 4);
    tick();
    chk("R10", "pulse ends", XLEN'(vec_w[0]), 0);

    for (int i = 0; i < 2000; i++) begin
      gen_req = ($urandom % 3) == 0;
      dbg_req = ($urandom % 5) == 0;
      stat_wr = ($urandom % 4) == 0;
      addr_vld = $urandom % 2;
      gen_cause = CW'($urandom); dbg_cause = DW'($urandom);
      gen_pc = $urandom; dbg_pc = $urandom; gen_addr = $urandom;
      stat_wd = SW'($urandom);
      @(negedge clk);
    end
    tick();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule